// File: doc/BRIEF.md
# Supply-Loss Write Guard

This controller sits between a host requester and a battery-backed memory. Three digitized comparator flags come in: supply under the deselect threshold, supply under the battery switchover level, and battery under its healthy level. While supply is out of tolerance the block refuses every host request. It keeps chip enable, write strobe and output enable low, so the memory's data pins float. It steers the backup source to the battery when supply sinks below switchover. After supply comes back it holds the memory off for a programmable number of clock cycles.

The host side is a valid/ready handshake. A request is taken in a cycle where `host_valid` and `host_ready` are both high. `host_we` picks write (1) or read (0). While `host_ready` is low the host must hold its request, and nothing reaches the memory. `host_ready` drops in the same cycle that the deselect flag rises, so a supply loss cuts a write short at once. Only the location being written at that moment can be damaged.

When supply returns, the battery flag is sampled once. If the battery is weak, the first accepted write is silently dropped and the flag then clears. Software can therefore find a low battery by writing a complement and reading it back.

Top module: `pfd_guard`

## Requirements
- R1: While `rst_n` is low, `host_ready`, `wr_allowed`, `mem_ce`, `mem_we`, `mem_oe` and `batt_flag_dbg` are 0.
- R2: In any cycle with `sup_low_desel` high, `host_ready`, `mem_ce`, `mem_we` and `mem_oe` are 0 in that same cycle, whatever the host drives.
- R3: If `sup_low_desel` is first sampled low at clock edge k, after being high, then `host_ready` stays 0 until edge k+REC_CYCLES. It is 1 after that edge while `sup_low_desel` stays low.
- R4: If `sup_low_desel` rises during the recovery wait, the wait is abandoned. The next return of supply starts a full REC_CYCLES wait again.
- R5: `batt_sel` equals `sup_low_swo` as sampled at the previous clock edge (1 = battery feeds the memory). This holds during reset too.
- R6: `batt_flag_dbg` takes the value of `bat_low_in` at the edge where the block leaves the deselected state. Changes of `bat_low_in` at any other time have no effect.
- R7: While `batt_flag_dbg` is 1, `wr_allowed` is 0. The first accepted write produces no `mem_we` pulse (`mem_ce` still pulses), and `batt_flag_dbg` is 0 from the next edge on.
- R8: With the flag clear and the host ready, an accepted write drives `mem_ce` and `mem_we` high and `mem_oe` low in the same cycle.
- R9: An accepted read drives `mem_ce` and `mem_oe` high and `mem_we` low. With no accepted request, all three are 0.
- R10: Requests made while `host_ready` is 0 (during deselect or the recovery wait) reach no memory pin and leave `batt_flag_dbg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_low_desel | input | 1 | Supply below deselect threshold |
| sup_low_swo | input | 1 | Supply below battery switchover level |
| bat_low_in | input | 1 | Battery below healthy level |
| host_valid | input | 1 | Host request valid |
| host_we | input | 1 | Request is a write (1) or read (0) |
| host_ready | output | 1 | Memory accessible; request accepted when valid |
| wr_allowed | output | 1 | A write now would be stored |
| mem_ce | output | 1 | Memory chip enable (active high) |
| mem_we | output | 1 | Memory write strobe (active high) |
| mem_oe | output | 1 | Memory output enable (active high) |
| batt_sel | output | 1 | Backup source is the battery |
| batt_flag_dbg | output | 1 | Battery-low flag, debug view |

## Verification
The assertions assume the comparator flags are already synchronous to `clk`, and that the deselect flag is high whenever the switchover flag is high. The bench drives all inputs at the falling edge only, and never lowers `sup_low_desel` while `sup_low_swo` is high. The assertions also take REC_CYCLES to be at least 1. The bench uses a short value, so several full recovery waits and one interrupted wait fit in the run. Host requests are presented in every power phase, which checks that requests are refused before the supply is valid.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_WAIT = 2'd1,
    PS_UP   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pfd_recovery_timer.sv
module pfd_recovery_timer #(
  parameter int REC_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desel_i,
  output logic wake_o,
  output logic up_o
);
  import pfd_pkg::*;
  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(REC_CYCLES);

  pwr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_DOWN;
      cnt_q   <= '0;
    end else if (desel_i) begin
      state_q <= PS_DOWN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PS_DOWN: begin
          state_q <= PS_WAIT;
          cnt_q   <= LOAD;
        end
        PS_WAIT: begin
          if (cnt_q <= CNT_W'(1)) begin
            state_q <= PS_UP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PS_UP:   state_q <= PS_UP;
        default: state_q <= PS_DOWN;
      endcase
    end
  end

  assign wake_o = (state_q == PS_DOWN) && !desel_i;
  assign up_o   = (state_q == PS_UP);

  // R3: the wait counter stays inside its loaded range
  assert_wait_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAIT) |-> (cnt_q != '0 && cnt_q <= LOAD));

  // R4: every entry into the wait starts from the full count
  assert_full_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_DOWN && state_q == PS_WAIT) |-> (cnt_q == LOAD));
endmodule

// File: rtl/pfd_batt_flag.sv
module pfd_batt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic bat_low_i,
  input  logic wr_acc_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (wake_i)             flag_q <= bat_low_i;
    else if (wr_acc_i && flag_q) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6: the flag is raised only on the way out of deselect
  assert_flag_sets_on_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wake_i));

  // R7: the flag falls only after a consumed write or a fresh sample
  assert_flag_clears_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(wr_acc_i) || $past(wake_i)));
endmodule

// File: rtl/pfd_bus_gate.sv
module pfd_bus_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic flag_i,
  input  logic valid_i,
  input  logic we_i,
  output logic ce_o,
  output logic we_o,
  output logic oe_o,
  output logic wr_acc_o,
  output logic wr_allowed_o
);
  logic take;

  assign take         = valid_i && ready_i;
  assign ce_o         = take;
  assign we_o         = take && we_i && !flag_i;
  assign oe_o         = take && !we_i;
  assign wr_acc_o     = take && we_i;
  assign wr_allowed_o = ready_i && !flag_i;

  // R7: a write under a set flag never strobes the array
  assert_swallow_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && valid_i && we_i) |-> !we_o);

  // R9: strobes are exclusive
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_o && oe_o));
endmodule

// File: rtl/pfd_guard.sv
module pfd_guard #(
  parameter int REC_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_low_desel,
  input  logic sup_low_swo,
  input  logic bat_low_in,
  input  logic host_valid,
  input  logic host_we,
  output logic host_ready,
  output logic wr_allowed,
  output logic mem_ce,
  output logic mem_we,
  output logic mem_oe,
  output logic batt_sel,
  output logic batt_flag_dbg
);
  logic wake, up, wr_acc, flag;
  logic batt_sel_q;

  pfd_recovery_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .desel_i(sup_low_desel),
    .wake_o (wake),
    .up_o   (up)
  );

  assign host_ready = up && !sup_low_desel;

  pfd_batt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_i   (wake),
    .bat_low_i(bat_low_in),
    .wr_acc_i (wr_acc),
    .flag_o   (flag)
  );

  pfd_bus_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (host_ready),
    .flag_i      (flag),
    .valid_i     (host_valid),
    .we_i        (host_we),
    .ce_o        (mem_ce),
    .we_o        (mem_we),
    .oe_o        (mem_oe),
    .wr_acc_o    (wr_acc),
    .wr_allowed_o(wr_allowed)
  );

  // Source selection keeps working while the control logic is in reset.
  always_ff @(posedge clk) batt_sel_q <= sup_low_swo;

  assign batt_sel      = batt_sel_q;
  assign batt_flag_dbg = flag;

  // R2: out-of-tolerance supply silences the memory in the same cycle
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_desel |-> (!host_ready && !mem_ce && !mem_we && !mem_oe));

  // R3: readiness never appears on a cycle that follows a deselect
  assert_ready_after_calm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> !$past(sup_low_desel));

  // R5: a steady low supply keeps the battery selected
  assert_battery_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_low_swo && $past(sup_low_swo)) |=> batt_sel);
endmodule

// File: tb/pfd_guard_tb.sv
`timescale 1ns/100ps
module pfd_guard_tb;
  localparam int REC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_low_desel = 1'b1, sup_low_swo = 1'b1, bat_low_in = 1'b0;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic host_ready, wr_allowed, mem_ce, mem_we, mem_oe, batt_sel, batt_flag_dbg;

  always #2 clk = ~clk;

  pfd_guard #(.REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sup_low_desel(sup_low_desel), .sup_low_swo(sup_low_swo),
    .bat_low_in(bat_low_in), .host_valid(host_valid), .host_we(host_we),
    .host_ready(host_ready), .wr_allowed(wr_allowed), .mem_ce(mem_ce), .mem_we(mem_we),
    .mem_oe(mem_oe), .batt_sel(batt_sel), .batt_flag_dbg(batt_flag_dbg)
  );

  typedef struct { logic [6:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  event mon_ev;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // staged stimulus
  logic s_rst = 1'b0, s_desel = 1'b1, s_swo = 1'b1, s_bat = 1'b0, s_val = 1'b0, s_we = 1'b0;
  // requirement model
  bit m_down = 1'b1, m_flag = 1'b0, m_bsel = 1'b1;
  int m_rec = 0;

  task automatic cyc(input string tag);
    exp_t e;
    bit rdy, ce;
    @(negedge clk);
    rst_n = s_rst; sup_low_desel = s_desel; sup_low_swo = s_swo;
    bat_low_in = s_bat; host_valid = s_val; host_we = s_we;
    #1;
    rdy = rst_n && !m_down && (m_rec == 0) && !s_desel;
    ce  = s_val && rdy;
    e.v = {rdy, rdy && !m_flag, ce, ce && s_we && !m_flag, ce && !s_we, m_bsel, m_flag};
    e.tag = tag;
    exp_q.push_back(e);
    -> mon_ev;
    @(posedge clk);
    m_bsel = s_swo;
    if (!s_rst) begin m_down = 1'b1; m_rec = 0; m_flag = 1'b0; end
    else if (s_desel) begin m_down = 1'b1; m_rec = 0; end
    else if (m_down) begin m_down = 1'b0; m_rec = REC; m_flag = s_bat; end
    else if (m_rec > 0) m_rec--;
    else if (s_val && s_we && m_flag) m_flag = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin : monitor
    exp_t e;
    logic [6:0] got;
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        got = {host_ready, wr_allowed, mem_ce, mem_we, mem_oe, batt_sel, batt_flag_dbg};
        checks++;
        if (got !== e.v) begin
          fails++;
          $display("FAIL %s at %0t: got %b expected %b (rdy,wa,ce,we,oe,bsel,flag)",
                   e.tag, $time, got, e.v);
        end
      end
    end
  end

  initial begin : stimulus
    s_val = 1'b1; s_we = 1'b1;
    run(3, "R1 reset state");
    s_rst = 1'b1;
    run(2, "R2 writes refused in deselect");
    s_swo = 1'b0;
    run(2, "R5 switchover released");
    s_desel = 1'b0; s_we = 1'b0;
    run(REC + 2, "R3 recovery wait then ready");
    s_we = 1'b1; cyc("R8 write");
    s_we = 1'b0; cyc("R9 read");
    s_val = 1'b0; cyc("R9 idle");
    s_val = 1'b1; s_we = 1'b1; cyc("R8 write again");
    s_bat = 1'b1;
    run(3, "R6 battery change ignored while up");
    s_desel = 1'b1;
    run(2, "R2 supply lost mid write");
    s_swo = 1'b1; cyc("R5 battery selected");
    s_swo = 1'b0; cyc("R5 battery released");
    s_desel = 1'b0;
    run(5, "R10 writes during wait ignored");
    s_desel = 1'b1; cyc("R4 wait abandoned");
    s_desel = 1'b0;
    run(REC - 1, "R4 full wait again");
    run(1, "R4 last wait cycle");
    s_val = 1'b0; s_bat = 1'b0;
    run(2, "R7 flag set, writes not allowed");
    s_val = 1'b1; s_we = 1'b1; cyc("R7 first write swallowed");
    cyc("R8 second write stored");
    s_bat = 1'b1; s_we = 1'b0;
    run(2, "R6 battery low later ignored");
    s_desel = 1'b1; run(2, "R2 deselect");
    s_bat = 1'b0; s_desel = 1'b0;
    run(REC + 2, "R6 healthy battery sampled on wake");
    s_we = 1'b1; cyc("R8 write with clear flag");
    s_rst = 1'b0; run(2, "R1 reset while up");
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(100000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule